// File: doc/BRIEF.md
# Parallel Instrument Bus Listener Handshake

This block is the acceptor half of the three-wire byte handshake on a parallel instrument bus. It watches the active-low data-valid, attention and interface-clear lines and eight active-low data lines. It answers on the not-ready-for-data and not-data-accepted lines. Both answer lines are wired-OR on the bus, so the block only produces pull-low enables (`1` pulls the line low, `0` lets it float high). Every byte it accepts is inverted to positive logic and handed to a local controller on a one-cycle strobe. The strobe carries two flags: whether attention was asserted during the transfer (command or data), and whether end-or-identify was asserted (last byte).

While idle, the block lets not-data-accepted float. It feeds the raw attention line straight onto its not-ready pull, so the bus sees "not ready" within gate delay of attention being asserted, well inside the 200 ns limit. The controller takes control by pulsing `next_req`. It can hold the bus not-ready with `hold_busy`, and after a byte it hands the lines back with `release_req`. A low interface-clear returns the block to idle from any state. All bus inputs pass through a configurable synchronizer chain. The only exception is the attention feed-through path.

Top module: `gpib_listen_handshake`

## Requirements
- R1: After `rst`, the block is idle: `ndac_pull`=0, `rx_valid`=0, and `nrfd_pull` equals the inverse of `bus_atn_n`.
- R2: While idle, `nrfd_pull` follows `bus_atn_n` combinationally, with no clock edge between them: `bus_atn_n`=0 gives `nrfd_pull`=1, and `bus_atn_n`=1 gives `nrfd_pull`=0.
- R3: A `next_req` sampled high in the idle or done state moves the block to ready at that edge. In ready, `nrfd_pull`=0 (when `hold_busy`=0) and `ndac_pull`=1.
- R4: With the default two-stage synchronizer, the third rising edge after `bus_dav_n` falls in ready sets `nrfd_pull`=1 while `ndac_pull` stays 1. The data is sampled in that cycle.
- R5: On the fourth rising edge after `bus_dav_n` falls, `rx_valid` is high for exactly one cycle and `ndac_pull` drops to 0 in the same cycle. At that point `rx_byte` = bitwise NOT of `bus_dio_n`, `rx_cmd` = NOT `bus_atn_n`, and `rx_last` = NOT `bus_eoi_n`. The end-or-identify level changes neither the timing nor the line behaviour.
- R6: Once `bus_dav_n` returns high, the third rising edge sets `ndac_pull`=1. From then on, `nrfd_pull` stays 1 until the next `next_req`.
- R7: While `hold_busy`=1 in ready, `nrfd_pull`=1 and a low `bus_dav_n` is ignored: no strobe occurs and `ndac_pull` stays 1. Once `hold_busy` drops, the waiting byte is accepted: the strobe comes on the second rising edge.
- R8: With the default synchronizer, `bus_ifc_n` held low returns the block to idle on the third rising edge, from any state.
- R9: A `release_req` sampled high in the done state returns the block to idle. It takes priority over `next_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_dav_n | input | 1 | Bus data-valid line, active low |
| bus_atn_n | input | 1 | Bus attention line, active low |
| bus_eoi_n | input | 1 | Bus end-or-identify line, active low |
| bus_ifc_n | input | 1 | Bus interface-clear line, active low |
| bus_dio_n | input | 8 | Bus data lines, active low |
| next_req | input | 1 | Controller asks for the next byte |
| hold_busy | input | 1 | Controller keeps the bus not-ready while in ready |
| release_req | input | 1 | Controller hands the lines back to idle after a byte |
| nrfd_pull | output | 1 | Pull-low enable for not-ready-for-data |
| ndac_pull | output | 1 | Pull-low enable for not-data-accepted |
| rx_valid | output | 1 | One-cycle strobe for an accepted byte |
| rx_byte | output | 8 | Accepted byte, positive logic |
| rx_cmd | output | 1 | Attention was asserted with the byte |
| rx_last | output | 1 | End-or-identify was asserted with the byte |

## Verification
The assertions assume that a talker obeys the handshake. Data and attention are settled before data-valid falls. Data-valid stays low until not-data-accepted is released. Interface-clear is held low for longer than the synchronizer depth. The stimulus follows these rules: it changes data, attention and end-or-identify two cycles before dropping data-valid, and it raises data-valid only after the release has been seen. Controller inputs change on falling edges and last one cycle. `hold_busy` is raised only before the block enters ready.

// File: rtl/lh_pkg.sv
package lh_pkg;

    localparam int LH_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READY  = 3'd1,
        ST_LATCH  = 3'd2,
        ST_ACCEPT = 3'd3,
        ST_DONE   = 3'd4
    } lh_state_e;

    // Raw bus sample, every field active low as seen on the wires.
    typedef struct packed {
        logic                 dav_n;
        logic                 atn_n;
        logic                 eoi_n;
        logic                 ifc_n;
        logic [LH_DATA_W-1:0] dio_n;
    } lh_bus_t;

    localparam int LH_BUS_W = $bits(lh_bus_t);

    // Accepted byte in positive logic with its qualifiers.
    typedef struct packed {
        logic [LH_DATA_W-1:0] value;
        logic                 is_cmd;
        logic                 is_last;
    } lh_rx_t;

    localparam lh_bus_t LH_BUS_IDLE = '{
        dav_n: 1'b1, atn_n: 1'b1, eoi_n: 1'b1, ifc_n: 1'b1, dio_n: '1
    };

    function automatic lh_rx_t lh_decode(input lh_bus_t b);
        lh_rx_t r;
        r.value   = ~b.dio_n;
        r.is_cmd  = ~b.atn_n;
        r.is_last = ~b.eoi_n;
        return r;
    endfunction

    function automatic logic lh_pulls_nrfd(input lh_state_e s, input logic hold);
        case (s)
            ST_READY:                     return hold;
            ST_LATCH, ST_ACCEPT, ST_DONE: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic logic lh_pulls_ndac(input lh_state_e s);
        case (s)
            ST_READY, ST_LATCH, ST_DONE: return 1'b1;
            default:                     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lh_sync.sv
module lh_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lh_fsm.sv
module lh_fsm
    import lh_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dav_s,
    input  logic      ifc_s,
    input  logic      next_req,
    input  logic      hold_busy,
    input  logic      release_req,
    output lh_state_e state_o,
    output logic      nrfd_pull_o,
    output logic      ndac_pull_o,
    output logic      take_o
);
    lh_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (next_req) state_d = ST_READY;
            ST_READY:  if (!dav_s && !hold_busy) state_d = ST_LATCH;
            ST_LATCH:  state_d = ST_ACCEPT;
            ST_ACCEPT: if (dav_s) state_d = ST_DONE;
            ST_DONE: begin
                if (release_req)   state_d = ST_IDLE;
                else if (next_req) state_d = ST_READY;
            end
            default:   state_d = ST_IDLE;
        endcase
        if (!ifc_s) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o     = state_q;
    assign nrfd_pull_o = lh_pulls_nrfd(state_q, hold_busy);
    assign ndac_pull_o = lh_pulls_ndac(state_q);
    assign take_o      = (state_q == ST_LATCH);

    // R8: a synchronized interface clear forces idle on the next edge
    assert_ifc_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !ifc_s |=> state_q == ST_IDLE);

    // R7: a held ready state does not react to data-valid
    assert_hold_stays_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READY && hold_busy && ifc_s) |=> state_q == ST_READY);

    // R6: accepted state lasts until data-valid is seen released
    assert_accept_waits_dav_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACCEPT && !dav_s && ifc_s) |=> state_q == ST_ACCEPT);

    // R9: release in done wins over a next-byte request
    assert_release_priority_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && release_req) |=> state_q == ST_IDLE);
endmodule

// File: rtl/lh_capture.sv
module lh_capture
    import lh_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take,
    input  lh_bus_t bus_s,
    output logic    valid_o,
    output lh_rx_t  rx_o
);
    lh_rx_t rx_q;
    logic   valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) rx_q <= lh_decode(bus_s);
        end
    end

    assign valid_o = valid_q;
    assign rx_o    = rx_q;

    // R5: the accepted-byte strobe never lasts longer than one cycle
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R5: contents stay put between strobes
    assert_rx_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(take) |-> $stable(rx_q));
endmodule

// File: rtl/gpib_listen_handshake.sv
module gpib_listen_handshake
    import lh_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_dav_n,
    input  logic                 bus_atn_n,
    input  logic                 bus_eoi_n,
    input  logic                 bus_ifc_n,
    input  logic [LH_DATA_W-1:0] bus_dio_n,
    input  logic                 next_req,
    input  logic                 hold_busy,
    input  logic                 release_req,
    output logic                 nrfd_pull,
    output logic                 ndac_pull,
    output logic                 rx_valid,
    output logic [LH_DATA_W-1:0] rx_byte,
    output logic                 rx_cmd,
    output logic                 rx_last
);
    lh_bus_t   bus_raw, bus_s;
    lh_state_e state;
    logic      fsm_nrfd, fsm_ndac, take;
    lh_rx_t    rx;

    assign bus_raw = '{dav_n: bus_dav_n, atn_n: bus_atn_n, eoi_n: bus_eoi_n,
                       ifc_n: bus_ifc_n, dio_n: bus_dio_n};

    lh_sync #(
        .W       (LH_BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LH_BUS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_raw),
        .q   (bus_s)
    );

    lh_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .dav_s       (bus_s.dav_n),
        .ifc_s       (bus_s.ifc_n),
        .next_req    (next_req),
        .hold_busy   (hold_busy),
        .release_req (release_req),
        .state_o     (state),
        .nrfd_pull_o (fsm_nrfd),
        .ndac_pull_o (fsm_ndac),
        .take_o      (take)
    );

    lh_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .bus_s   (bus_s),
        .valid_o (rx_valid),
        .rx_o    (rx)
    );

    // Idle: the raw attention line drives the not-ready pull without a register.
    assign nrfd_pull = fsm_nrfd | ((state == ST_IDLE) & ~bus_atn_n);
    assign ndac_pull = fsm_ndac;
    assign rx_byte   = rx.value;
    assign rx_cmd    = rx.is_cmd;
    assign rx_last   = rx.is_last;

    // R5: the strobe coincides with the accept release
    assert_strobe_with_release_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !ndac_pull);

    // R4: data is taken only while not-ready is pulled
    assert_take_under_nrfd_R4: assert property (@(posedge clk) disable iff (rst)
        take |-> (nrfd_pull && ndac_pull));

    // R6: outside idle, never both lines released together
    assert_never_both_free_R6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !hold_busy) |-> (nrfd_pull || ndac_pull || state == ST_READY));

    // R3: ready holds not-data-accepted low
    assert_ready_holds_ndac_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY) |-> ndac_pull);
endmodule

// File: tb/gpib_listen_handshake_tb.sv
module gpib_listen_handshake_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dav_n = 1'b1, atn_n = 1'b1, eoi_n = 1'b1, ifc_n = 1'b1;
    logic [7:0] dio_n = 8'hFF;
    logic       next_req = 1'b0, hold_busy = 1'b0, release_req = 1'b0;
    logic       nrfd_pull, ndac_pull, rx_valid, rx_cmd, rx_last;
    logic [7:0] rx_byte;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit done = 1'b0;

    // Each entry: {atn_n, eoi_n, dio_n}
    localparam logic [9:0] VEC [6] = '{
        {1'b0, 1'b1, 8'hDB},   // command byte 0x24
        {1'b0, 1'b1, 8'h9F},   // command byte 0x60
        {1'b1, 1'b1, 8'hB7},   // data 0x48
        {1'b1, 1'b1, 8'h96},   // data 0x69
        {1'b1, 1'b0, 8'hF2},   // last data 0x0D
        {1'b0, 1'b1, 8'hC0}    // command 0x3F
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    gpib_listen_handshake dut_i (
        .clk (clk), .rst (rst),
        .bus_dav_n (dav_n), .bus_atn_n (atn_n), .bus_eoi_n (eoi_n),
        .bus_ifc_n (ifc_n), .bus_dio_n (dio_n),
        .next_req (next_req), .hold_busy (hold_busy), .release_req (release_req),
        .nrfd_pull (nrfd_pull), .ndac_pull (ndac_pull), .rx_valid (rx_valid),
        .rx_byte (rx_byte), .rx_cmd (rx_cmd), .rx_last (rx_last)
    );

    always @(negedge clk) if (!rst && rx_valid) strobes++;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ncyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_next();
        next_req = 1'b1; ncyc(1); next_req = 1'b0;
    endtask

    // One full transfer from ready, checking R4, R5, R6 timing.
    task automatic xfer(input logic [9:0] v);
        logic [7:0] exp_b;
        exp_b = ~v[7:0];
        atn_n = v[9]; eoi_n = v[8]; dio_n = v[7:0];
        ncyc(2);
        dav_n = 1'b0;
        ncyc(3);
        check(nrfd_pull === 1'b1 && ndac_pull === 1'b1, "R4 nrfd pulled before accept",
              {nrfd_pull, ndac_pull}, 2'b11);
        ncyc(1);
        check(rx_valid === 1'b1 && ndac_pull === 1'b0, "R5 strobe with ndac release",
              {rx_valid, ndac_pull}, 2'b10);
        check(rx_byte === exp_b, "R5 byte inverted", rx_byte, exp_b);
        check(rx_cmd === ~v[9] && rx_last === ~v[8], "R5 cmd/last flags",
              {rx_cmd, rx_last}, {~v[9], ~v[8]});
        dav_n = 1'b1;
        ncyc(1);
        check(rx_valid === 1'b0, "R5 strobe one cycle", rx_valid, 0);
        ncyc(2);
        check(ndac_pull === 1'b1 && nrfd_pull === 1'b1, "R6 done pulls both",
              {nrfd_pull, ndac_pull}, 2'b11);
        ncyc(2);
        check(nrfd_pull === 1'b1, "R6 nrfd held until request", nrfd_pull, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int s0;
        ncyc(3);
        rst = 1'b0;
        ncyc(1);
        // R1 reset state
        check(ndac_pull === 1'b0 && rx_valid === 1'b0 && nrfd_pull === 1'b0,
              "R1 reset idle", {nrfd_pull, ndac_pull, rx_valid}, 3'b000);

        // R2 combinational feed-through, sampled between edges
        #1 atn_n = 1'b0; #1;
        check(nrfd_pull === 1'b1, "R2 atn low pulls nrfd", nrfd_pull, 1);
        atn_n = 1'b1; #1;
        check(nrfd_pull === 1'b0, "R2 atn high frees nrfd", nrfd_pull, 0);
        ncyc(1);

        // R3 enter ready
        pulse_next();
        check(nrfd_pull === 1'b0 && ndac_pull === 1'b1, "R3 ready lines",
              {nrfd_pull, ndac_pull}, 2'b01);

        // Table walk
        for (int k = 0; k < 6; k++) begin
            xfer(VEC[k]);
            pulse_next();
            check(nrfd_pull === 1'b0 && ndac_pull === 1'b1, "R3 ready after done",
                  {nrfd_pull, ndac_pull}, 2'b01);
        end
        check(strobes == 6, "R5 strobe count", strobes, 6);

        // R9 release beats next request
        xfer({1'b1, 1'b1, 8'h00});
        release_req = 1'b1; next_req = 1'b1; ncyc(1);
        release_req = 1'b0; next_req = 1'b0;
        check(ndac_pull === 1'b0 && nrfd_pull === 1'b0, "R9 back to idle",
              {nrfd_pull, ndac_pull}, 2'b00);
        atn_n = 1'b0; #1;
        check(nrfd_pull === 1'b1, "R9 idle follows atn", nrfd_pull, 1);
        atn_n = 1'b1;
        ncyc(1);

        // R7 hold keeps bus not-ready and ignores data-valid
        hold_busy = 1'b1;
        pulse_next();
        check(nrfd_pull === 1'b1 && ndac_pull === 1'b1, "R7 held ready lines",
              {nrfd_pull, ndac_pull}, 2'b11);
        dio_n = 8'h5A; atn_n = 1'b1; eoi_n = 1'b1;
        ncyc(2);
        s0 = strobes;
        dav_n = 1'b0;
        ncyc(6);
        check(strobes == s0 && ndac_pull === 1'b1, "R7 dav ignored while held",
              strobes - s0, 0);
        hold_busy = 1'b0;
        ncyc(2);
        check(rx_valid === 1'b1 && rx_byte === 8'hA5, "R7 accepted after hold",
              {rx_valid, rx_byte}, {1'b1, 8'hA5});
        dav_n = 1'b1;
        ncyc(3);

        // R8 interface clear from done
        check(ndac_pull === 1'b1, "R8 precondition done", ndac_pull, 1);
        ifc_n = 1'b0;
        ncyc(3);
        check(ndac_pull === 1'b0 && nrfd_pull === 1'b0, "R8 ifc returns idle",
              {nrfd_pull, ndac_pull}, 2'b00);
        ifc_n = 1'b1;
        ncyc(3);
        pulse_next();
        check(ndac_pull === 1'b1, "R8 usable after clear", ndac_pull, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule